// File: doc/BRIEF.md
# Masked Address/Data Break Comparator

This block is a single hardware breakpoint channel. It watches a processor's address bus and one of four data buses, and it raises a one-clock break pulse when a programmed condition matches. The four data buses are a 32-bit internal bus, a 32-bit local bus, a 16-bit X-memory bus and a 16-bit Y-memory bus. Each bus carries its own transfer strobe.

Software programs the channel through a small register port. There are three 32-bit registers (break address, address mask and break data) and a 4-bit control field that chooses which data bus takes part. A mask bit of 1 removes that address bit from the comparison. The two 16-bit buses are compared against opposite halves of the data register: X against the upper half, Y against the lower half.

Top module: `break_watch`

## Requirements
- R1: After reset all four register reads return zero and `breakPulse` is low.
- R2: Register offsets are 0 for break address, 1 for address mask, 2 for break data and 3 for control. The three 32-bit registers read back what was written. The control register keeps only bits 3..0 and reads zero in bits 31..4.
- R3: For each address bit, a mask bit of 1 excludes that bit from the address match and a mask bit of 0 requires it to equal the break address.
- R4: Control bit 2 = 0 with bits 1..0 = 01 selects the internal bus. A hit then requires `iStrobe` and all 32 bits of `iData` equal to the break data.
- R5: Control bit 2 = 0 with bits 1..0 = 10 selects the local bus. A hit then requires `lStrobe` and all 32 bits of `lData` equal to the break data.
- R6: Control bit 2 = 1 with bit 3 = 0 selects X memory. A hit then requires `xStrobe` and `xData` equal to break data bits 31..16. Break data bits 15..0 have no effect.
- R7: Control bit 2 = 1 with bit 3 = 1 selects Y memory. A hit then requires `yStrobe` and `yData` equal to break data bits 15..0. Break data bits 31..16 have no effect.
- R8: Control bit 2 = 0 with bits 1..0 = 00 or 11 turns the data comparison off. Any of the four strobes together with an address match then gives a hit.
- R9: When a bus is selected, the strobes and data of the other three buses have no effect.
- R10: `breakPulse` goes high on the clock after a qualifying bus cycle and stays high for exactly one cycle for each qualifying cycle.
- R11: A register write takes effect from the next clock. A bus cycle on the same clock as the write is compared against the old value.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| busAddr | input | 32 | Processor address under watch |
| iStrobe | input | 1 | Internal bus transfer valid |
| iData | input | 32 | Internal bus data |
| lStrobe | input | 1 | Local bus transfer valid |
| lData | input | 32 | Local bus data |
| xStrobe | input | 1 | X-memory transfer valid |
| xData | input | 16 | X-memory data |
| yStrobe | input | 1 | Y-memory transfer valid |
| yData | input | 16 | Y-memory data |
| breakPulse | output | 1 | Registered break request |

## Verification
The hardest case to reach from the ports is the one where a register write and a bus cycle that matches only the old value fall on the same edge. The bench raises the write strobe and the bus strobe on the same negative edge. It then expects a hit from the old address and, one clock later, a miss against the new address. The lane placement of the two 16-bit buses is also hard to see. The bench checks it by flipping every bit of each bus one at a time, and by changing the unused half of the data register while keeping the same bus data. A sweep over all 16 control codes, all 16 strobe patterns and all four match patterns checks bus selection against an arithmetic model.

// File: rtl/break_watch_pkg.sv
`timescale 1ns/1ps
package break_watch_pkg;
  localparam int NUM_BUS = 4;
  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    BUS_I = 2'd0,
    BUS_L = 2'd1,
    BUS_X = 2'd2,
    BUS_Y = 2'd3
  } busId_e;

  localparam logic [1:0] RA_ADDR = 2'd0;
  localparam logic [1:0] RA_MASK = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_CTL  = 2'd3;

  // control to datapath: register write strobes and one-hot bus choice
  typedef struct packed {
    logic               wrAddr;
    logic               wrMask;
    logic               wrData;
    logic [NUM_BUS-1:0] busSel;
    logic               anyBus;
  } ctlStrobes_t;
endpackage

// File: rtl/break_watch_ctrl.sv
`timescale 1ns/1ps
module break_watch_ctrl
  import break_watch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CTL_W-1:0] regWrCtl,
  output ctlStrobes_t      strobes,
  output logic [CTL_W-1:0] ctlValue
);
  logic [CTL_W-1:0] ctlReg;
  logic [1:0]       dbSel;
  logic             xyEn;
  logic             xySel;

  always_ff @(posedge clk) begin
    if (!rstN) ctlReg <= '0;
    else if (regWrEn && regAddr == RA_CTL) ctlReg <= regWrCtl;
  end

  assign dbSel    = ctlReg[1:0];
  assign xyEn     = ctlReg[2];
  assign xySel    = ctlReg[3];
  assign ctlValue = ctlReg;

  always_comb begin
    strobes        = '0;
    strobes.wrAddr = regWrEn && (regAddr == RA_ADDR);
    strobes.wrMask = regWrEn && (regAddr == RA_MASK);
    strobes.wrData = regWrEn && (regAddr == RA_DATA);
    if (xyEn) begin
      if (xySel) strobes.busSel[BUS_Y] = 1'b1;
      else       strobes.busSel[BUS_X] = 1'b1;
    end else begin
      case (dbSel)
        2'b01:   strobes.busSel[BUS_I] = 1'b1;
        2'b10:   strobes.busSel[BUS_L] = 1'b1;
        default: strobes.anyBus        = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/break_watch_dp.sv
`timescale 1ns/1ps
module break_watch_dp
  import break_watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [CTL_W-1:0]    ctlValue,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_BUS-1:0]  busStrb,
  input  logic [DATA_W-1:0]   iData,
  input  logic [DATA_W-1:0]   lData,
  input  logic [DATA_W/2-1:0] xData,
  input  logic [DATA_W/2-1:0] yData,
  output logic                breakPulse
);
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0]  addrReg;
  logic [ADDR_W-1:0]  maskReg;
  logic [DATA_W-1:0]  dataReg;
  logic               addrHit;
  logic [NUM_BUS-1:0] laneHit;
  logic [NUM_BUS-1:0] laneQual;
  logic               dataOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      maskReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.wrAddr) addrReg <= regWrData[ADDR_W-1:0];
      if (strobes.wrMask) maskReg <= regWrData[ADDR_W-1:0];
      if (strobes.wrData) dataReg <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RA_ADDR: regRdData[ADDR_W-1:0] = addrReg;
      RA_MASK: regRdData[ADDR_W-1:0] = maskReg;
      RA_DATA: regRdData             = dataReg;
      default: regRdData[CTL_W-1:0]  = ctlValue;
    endcase
  end

  assign addrHit = ((busAddr ^ addrReg) & ~maskReg) == '0;

  // lane placement: X meets the upper half of the data register, Y the lower
  assign laneHit[BUS_I] = (iData == dataReg);
  assign laneHit[BUS_L] = (lData == dataReg);
  assign laneHit[BUS_X] = (xData == dataReg[DATA_W-1:HALF_W]);
  assign laneHit[BUS_Y] = (yData == dataReg[HALF_W-1:0]);

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
    assign laneQual[g] = strobes.busSel[g] & busStrb[g] & laneHit[g];
  end

  assign dataOk = (|laneQual) | (strobes.anyBus & (|busStrb));

  always_ff @(posedge clk) begin
    if (!rstN) breakPulse <= 1'b0;
    else       breakPulse <= addrHit & dataOk;
  end
endmodule

// File: rtl/break_watch.sv
`timescale 1ns/1ps
module break_watch
  import break_watch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                iStrobe,
  input  logic [DATA_W-1:0]   iData,
  input  logic                lStrobe,
  input  logic [DATA_W-1:0]   lData,
  input  logic                xStrobe,
  input  logic [DATA_W/2-1:0] xData,
  input  logic                yStrobe,
  input  logic [DATA_W/2-1:0] yData,
  output logic                breakPulse
);
  ctlStrobes_t        strobes;
  logic [CTL_W-1:0]   ctlValue;
  logic [NUM_BUS-1:0] busStrb;

  assign busStrb = {yStrobe, xStrobe, lStrobe, iStrobe};

  break_watch_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrCtl (regWrData[CTL_W-1:0]),
    .strobes  (strobes),
    .ctlValue (ctlValue)
  );

  break_watch_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .ctlValue   (ctlValue),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .busAddr    (busAddr),
    .busStrb    (busStrb),
    .iData      (iData),
    .lData      (lData),
    .xData      (xData),
    .yData      (yData),
    .breakPulse (breakPulse)
  );
endmodule

// File: rtl/break_watch_chk.sv
`timescale 1ns/1ps
module break_watch_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [1:0]          regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   regRdData,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                iStrobe,
  input logic [DATA_W-1:0]   iData,
  input logic                lStrobe,
  input logic [DATA_W-1:0]   lData,
  input logic                xStrobe,
  input logic [DATA_W/2-1:0] xData,
  input logic                yStrobe,
  input logic [DATA_W/2-1:0] yData,
  input logic                breakPulse
);
  localparam int HALF_W = DATA_W / 2;

  // shadow copies built from the write port only
  logic [ADDR_W-1:0] shAddr;
  logic [ADDR_W-1:0] shMask;
  logic [DATA_W-1:0] shData;
  logic [3:0]        shCtl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shAddr <= '0;
      shMask <= '0;
      shData <= '0;
      shCtl  <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        2'd0:    shAddr <= regWrData[ADDR_W-1:0];
        2'd1:    shMask <= regWrData[ADDR_W-1:0];
        2'd2:    shData <= regWrData;
        default: shCtl  <= regWrData[3:0];
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !breakPulse);

  a_r2_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 2'd3 |-> regRdData[DATA_W-1:4] == '0);

  a_r3_addr_masked: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> $past(((busAddr ^ shAddr) & ~shMask) == '0));

  a_r4_internal_bus: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse && $past(shCtl[2:0] == 3'b001) |-> $past(iStrobe && iData == shData));

  a_r5_local_bus: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse && $past(shCtl[2:0] == 3'b010) |-> $past(lStrobe && lData == shData));

  a_r6_x_upper_lane: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse && $past(shCtl[3:2] == 2'b01)
      |-> $past(xStrobe && xData == shData[DATA_W-1:HALF_W]));

  a_r7_y_lower_lane: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse && $past(shCtl[3:2] == 2'b11)
      |-> $past(yStrobe && yData == shData[HALF_W-1:0]));

  a_r10_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> $past(iStrobe | lStrobe | xStrobe | yStrobe));
endmodule

bind break_watch break_watch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_break_watch.sv
`timescale 1ns/1ps
module test_break_watch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] busAddr = '0;
  logic        iStrobe = 1'b0, lStrobe = 1'b0, xStrobe = 1'b0, yStrobe = 1'b0;
  logic [31:0] iData = '0, lData = '0;
  logic [15:0] xData = '0, yData = '0;
  logic        breakPulse;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mAddr = '0, mMask = '0, mData = '0;
  logic [3:0]  mCtl = '0;

  always #10 clk = ~clk;

  break_watch i_break_watch (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busAddr(busAddr),
    .iStrobe(iStrobe), .iData(iData), .lStrobe(lStrobe), .lData(lData),
    .xStrobe(xStrobe), .xData(xData), .yStrobe(yStrobe), .yData(yData),
    .breakPulse(breakPulse)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model(input logic [31:0] a, input logic [3:0] s,
      input logic [31:0] i, input logic [31:0] l, input logic [15:0] x, input logic [15:0] y);
    logic aOk, dOk;
    aOk = ((a ^ mAddr) & ~mMask) == 32'd0;
    if (mCtl[2]) begin
      if (mCtl[3]) dOk = s[3] && (y == mData[15:0]);
      else         dOk = s[2] && (x == mData[31:16]);
    end else begin
      case (mCtl[1:0])
        2'b01:   dOk = s[0] && (i == mData);
        2'b10:   dOk = s[1] && (l == mData);
        default: dOk = |s;
      endcase
    end
    return aOk && dOk;
  endfunction

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      2'd0:    mAddr = d;
      2'd1:    mMask = d;
      2'd2:    mData = d;
      default: mCtl  = d[3:0];
    endcase
  endtask

  task automatic rdCheck(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData, exp, req);
  endtask

  // drive one bus cycle, then check the pulse and its fall (R10)
  task automatic busTry(input logic [31:0] a, input logic [3:0] s, input logic [31:0] i,
      input logic [31:0] l, input logic [15:0] x, input logic [15:0] y, input string req);
    logic exp;
    exp = model(a, s, i, l, x, y);
    @(negedge clk);
    busAddr = a; iData = i; lData = l; xData = x; yData = y;
    {yStrobe, xStrobe, lStrobe, iStrobe} = s;
    @(negedge clk);
    check({31'd0, breakPulse}, {31'd0, exp}, req);
    {yStrobe, xStrobe, lStrobe, iStrobe} = 4'd0;
    @(negedge clk);
    check({31'd0, breakPulse}, 32'd0, "R10 pulse lasts one cycle");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check({31'd0, breakPulse}, 32'd0, "R1 pulse low after reset");
    rdCheck(2'd0, 32'd0, "R1 addr reset");
    rdCheck(2'd1, 32'd0, "R1 mask reset");
    rdCheck(2'd2, 32'd0, "R1 data reset");
    rdCheck(2'd3, 32'd0, "R1 ctl reset");

    // R2 read back
    wrReg(2'd0, 32'hDEAD_BEEF); rdCheck(2'd0, 32'hDEAD_BEEF, "R2 addr");
    wrReg(2'd1, 32'h0F0F_1234); rdCheck(2'd1, 32'h0F0F_1234, "R2 mask");
    wrReg(2'd2, 32'h8765_4321); rdCheck(2'd2, 32'h8765_4321, "R2 data");
    wrReg(2'd3, 32'hFFFF_FFFF); rdCheck(2'd3, 32'h0000_000F, "R2 ctl upper zero");
    wrReg(2'd3, 32'h0000_0000); rdCheck(2'd3, 32'h0000_0000, "R2 ctl clear");

    // R3 mask sweep, data compare off (R8)
    wrReg(2'd0, 32'd0);
    for (int k = 0; k < 32; k++) begin
      wrReg(2'd1, ~(32'd1 << k));
      busTry(32'd1 << k, 4'b0001, '0, '0, '0, '0, "R3 unmasked bit differs");
      busTry(~(32'd1 << k), 4'b0001, '0, '0, '0, '0, "R3 masked bits ignored");
      wrReg(2'd1, 32'd1 << k);
      busTry(32'd1 << k, 4'b0001, '0, '0, '0, '0, "R3 single masked bit ignored");
    end
    wrReg(2'd1, 32'd0);
    busTry(32'd4, 4'b0001, '0, '0, '0, '0, "R3 zero mask compares all bits");

    wrReg(2'd0, 32'h1234_5670);
    wrReg(2'd2, 32'hA5A5_0F0F);

    // R4 internal bus, every bit
    wrReg(2'd3, 32'h1);
    busTry(32'h1234_5670, 4'b0001, 32'hA5A5_0F0F, '0, '0, '0, "R4 internal match");
    for (int b = 0; b < 32; b++)
      busTry(32'h1234_5670, 4'b0001, 32'hA5A5_0F0F ^ (32'd1 << b), '0, '0, '0, "R4 internal bit flip");

    // R5 local bus, every bit
    wrReg(2'd3, 32'h2);
    busTry(32'h1234_5670, 4'b0010, '0, 32'hA5A5_0F0F, '0, '0, "R5 local match");
    for (int b = 0; b < 32; b++)
      busTry(32'h1234_5670, 4'b0010, '0, 32'hA5A5_0F0F ^ (32'd1 << b), '0, '0, "R5 local bit flip");

    // R6 X lane against upper half, lower half ignored
    wrReg(2'd3, 32'h4);
    for (int b = 0; b < 16; b++)
      busTry(32'h1234_5670, 4'b0100, '0, '0, 16'hA5A5 ^ (16'd1 << b), '0, "R6 X bit flip");
    for (int v = 0; v < 4; v++) begin
      wrReg(2'd2, {16'hA5A5, 16'h1111 * v[15:0]});
      busTry(32'h1234_5670, 4'b0100, '0, '0, 16'hA5A5, '0, "R6 X low half ignored");
    end

    // R7 Y lane against lower half, upper half ignored
    wrReg(2'd3, 32'hC);
    wrReg(2'd2, 32'h0000_3C96);
    for (int b = 0; b < 16; b++)
      busTry(32'h1234_5670, 4'b1000, '0, '0, '0, 16'h3C96 ^ (16'd1 << b), "R7 Y bit flip");
    for (int v = 0; v < 4; v++) begin
      wrReg(2'd2, {16'h2222 * v[15:0], 16'h3C96});
      busTry(32'h1234_5670, 4'b1000, '0, '0, '0, 16'h3C96, "R7 Y high half ignored");
    end

    // R8 data compare off for select 00 and 11
    wrReg(2'd3, 32'h3);
    for (int s = 0; s < 4; s++)
      busTry(32'h1234_5670, 4'd1 << s, 32'h1, 32'h2, 16'h3, 16'h4, "R8 sel 11 any strobe");
    wrReg(2'd3, 32'h0);
    busTry(32'h1234_5670, 4'b0000, '0, '0, '0, '0, "R8 no strobe no break");

    // R9 sweep over control, strobes and match patterns
    wrReg(2'd2, 32'h5A3C_C35A);
    for (int c = 0; c < 16; c++) begin
      wrReg(2'd3, c);
      for (int s = 0; s < 16; s++)
        for (int m = 0; m < 4; m++)
          busTry(32'h1234_5670, s[3:0],
                 m[0] ? 32'h5A3C_C35A : 32'h5A3C_C35B,
                 m[1] ? 32'h5A3C_C35A : 32'h5A3C_C35B,
                 m[0] ? 16'h5A3C : 16'h5A3D,
                 m[1] ? 16'hC35A : 16'hC35B,
                 "R9 selection sweep");
    end

    // R11 write and bus cycle on the same edge
    wrReg(2'd3, 32'h0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h0BAD_F00D;
    busAddr = 32'h1234_5670; iStrobe = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    mAddr = 32'h0BAD_F00D;
    check({31'd0, breakPulse}, 32'd1, "R11 same-edge uses old address");
    @(negedge clk);
    check({31'd0, breakPulse}, 32'd0, "R11 new address in force");
    busAddr = 32'h0BAD_F00D;
    @(negedge clk);
    check({31'd0, breakPulse}, 32'd1, "R11 new address hits");
    @(negedge clk);
    check({31'd0, breakPulse}, 32'd1, "R10 back-to-back cycles pulse again");
    iStrobe = 1'b0;
    @(negedge clk);
    check({31'd0, breakPulse}, 32'd0, "R10 pulse ends");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule